// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of a synchronous DRAM burst, one per clock. When a read or write command arrives, the command logic pulses a load input and presents the starting column. The sequencer then steps through the columns of the burst in the programmed order, which is sequential or interleaved. It raises a flag on the beat that carries the last address of a fixed-length burst.

The burst length and the ordering are captured together with the starting column. A mode change while a burst is running therefore affects only later bursts. A full-page burst walks every column of the open row, wraps from the top column to zero, and keeps going until a stop request arrives. A new load may arrive on any cycle, including in the middle of a burst, and restarts the sequence at the new column.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `col_valid` and `burst_last` are both 0.
- R2: On the cycle after `cmd_load` is sampled high, `col_valid` is 1 and `col_addr` equals the `load_col` value sampled with it.
- R3: A burst of fixed length L presents exactly L addresses on consecutive cycles, one per clock. `col_valid` is 0 on the cycle after the last one.
- R4: In sequential order (`order_ilv`=0), beat i has low log2(L) bits equal to (start low bits + i) mod L. The bits above them equal those of the starting column.
- R5: In interleaved order (`order_ilv`=1), beat i has low log2(L) bits equal to the start low bits XOR i. The upper bits equal those of the starting column.
- R6: `burst_last` is 1 only on the beat that presents the last address of a fixed-length burst.
- R7: Length code 7 selects a full-page burst. It is always sequential whatever `order_ilv` says, wraps from column 511 to 0, and never raises `burst_last`.
- R8: `burst_stop` sampled high during a burst, with no load in the same cycle, makes `col_valid` 0 on the next cycle.
- R9: `cmd_load` during a burst restarts the sequence from the new column with the new mode. A load wins over `burst_stop` in the same cycle.
- R10: Changes on `burst_len_sel` and `order_ilv` while a burst runs have no effect on that burst's addresses or length.
- R11: Length codes: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. The reserved codes 4 to 6 give 1 beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_load | input | 1 | Start a burst at `load_col` |
| load_col | input | 9 | Starting column |
| burst_len_sel | input | 3 | Length code, captured at load |
| order_ilv | input | 1 | 1 = interleaved order, captured at load |
| burst_stop | input | 1 | End the current burst |
| col_addr | output | 9 | Current column address |
| col_valid | output | 1 | `col_addr` holds a burst beat |
| burst_last | output | 1 | Beat is the last of a fixed-length burst |

## Verification
Every fixed length is tried in both orders from all 512 starting columns. This separates carry into the upper bits from correct wrapping inside the aligned block, and XOR ordering from addition. Each run also scrambles the mode inputs right after the load, which exposes any design that reads the mode live instead of capturing it. A long full-page run that starts near the top column shows the wrap to zero and the absence of a last-beat flag. Directed stop and mid-burst reload cases, plus the reserved length codes, cover early ending, restart priority and the single-beat fallback.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;

  // number of low column bits that wrap for a fixed length code (R11)
  function automatic int unsigned bl_log2(input logic [2:0] code);
    case (code)
      BL_TWO:   return 1;
      BL_FOUR:  return 2;
      BL_EIGHT: return 3;
      default:  return 0;
    endcase
  endfunction

  function automatic logic bl_is_page(input logic [2:0] code);
    return code == BL_PAGE;
  endfunction
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec #(
  parameter int COL_W = 9
) (
  input  logic [2:0]       len_code,
  output logic [COL_W-1:0] wrap_mask,
  output logic             page
);
  import burst_pkg::*;

  always_comb begin
    page = bl_is_page(len_code);
    for (int b = 0; b < COL_W; b++) begin
      wrap_mask[b] = page || (b < bl_log2(len_code));
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low;

  always_comb begin
    low = ilv ? (base ^ beat) : (base + beat);
    col = (base & ~wrap_mask) | (low & wrap_mask);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             stop,
  input  logic [COL_W-1:0] start_in,
  input  logic [COL_W-1:0] mask_in,
  input  logic             page_in,
  input  logic             ilv_in,
  output logic             valid,
  output logic             last,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] mask,
  output logic             ilv
);
  logic page_r;
  logic at_end;

  assign at_end = valid && !page_r && (beat == mask);
  assign last   = at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      beat   <= '0;
      base   <= '0;
      mask   <= '0;
      ilv    <= 1'b0;
      page_r <= 1'b0;
    end else if (load) begin
      valid  <= 1'b1;
      beat   <= '0;
      base   <= start_in;
      mask   <= mask_in;
      ilv    <= ilv_in && !page_in;
      page_r <= page_in;
    end else if (valid) begin
      if (stop || at_end) valid <= 1'b0;
      else                beat  <= beat + 1'b1;
    end
  end

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid && beat == '0);  // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    valid && stop && !load |=> !valid);  // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last && !load |=> !valid);  // R6
  AST_RUN_ON: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !last && !stop && !load |=> valid && beat == COL_W'($past(beat) + 1'b1));  // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    valid && !load |=> mask == $past(mask) && ilv == $past(ilv));  // R10
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_load,
  input  logic [COL_W-1:0] load_col,
  input  logic [2:0]       burst_len_sel,
  input  logic             order_ilv,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             burst_last
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page;
  logic [COL_W-1:0] beat_w;
  logic [COL_W-1:0] base_w;
  logic [COL_W-1:0] mask_w;
  logic             ilv_w;

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code (burst_len_sel),
    .wrap_mask(dec_mask),
    .page     (dec_page)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_load),
    .stop    (burst_stop),
    .start_in(load_col),
    .mask_in (dec_mask),
    .page_in (dec_page),
    .ilv_in  (order_ilv),
    .valid   (col_valid),
    .last    (burst_last),
    .beat    (beat_w),
    .base    (base_w),
    .mask    (mask_w),
    .ilv     (ilv_w)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .base     (base_w),
    .beat     (beat_w),
    .wrap_mask(mask_w),
    .ilv      (ilv_w),
    .col      (col_addr)
  );

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !cmd_load && !burst_stop && !burst_last
    |=> (col_addr & ~mask_w) == ($past(col_addr) & ~$past(mask_w)));  // R4
  AST_LOAD_COL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> col_addr == $past(load_col));  // R2
  AST_LAST_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    burst_last |-> col_valid);  // R6
endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_load = 1'b0;
  logic [8:0] load_col = '0;
  logic [2:0] burst_len_sel = '0;
  logic       order_ilv = 1'b0;
  logic       burst_stop = 1'b0;
  logic [8:0] col_addr;
  logic       col_valid;
  logic       burst_last;

  int nchk = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  burst_col_gen i_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .load_col(load_col),
    .burst_len_sel(burst_len_sel), .order_ilv(order_ilv), .burst_stop(burst_stop),
    .col_addr(col_addr), .col_valid(col_valid), .burst_last(burst_last)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_col(input int start, input int len, input bit ilv, input int i);
    int off = start % len;
    int blk = start - off;
    return ilv ? blk + (off ^ i) : blk + ((off + i) % len);
  endfunction

  function automatic int code_len(input int code);
    return (code <= 3) ? (1 << code) : 1;
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // load and follow one fixed-length burst; mode inputs are scrambled after load (R10)
  task automatic run_fixed(input int code, input bit ilv, input int start);
    int len = code_len(code);
    @(negedge clk);
    cmd_load = 1'b1; load_col = 9'(start); burst_len_sel = 3'(code); order_ilv = ilv;
    @(negedge clk);
    cmd_load = 1'b0; burst_len_sel = 3'd7; order_ilv = ~ilv; load_col = ~9'(start);
    for (int i = 0; i < len; i++) begin
      chk(col_valid == 1'b1, "R2 R3 valid during burst", int'(col_valid), 1);
      chk(int'(col_addr) == exp_col(start, len, ilv, i),
          ilv ? "R5 R10 R11 interleaved column" : "R4 R10 R11 sequential column",
          int'(col_addr), exp_col(start, len, ilv, i));
      chk(burst_last == (i == len - 1), "R6 last flag", int'(burst_last), int'(i == len - 1));
      @(negedge clk);
    end
    chk(col_valid == 1'b0, "R3 valid drops after last beat", int'(col_valid), 0);
    chk(burst_last == 1'b0, "R6 last flag after burst", int'(burst_last), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(col_valid == 1'b0, "R1 valid in reset", int'(col_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(col_valid == 1'b0, "R1 valid after reset", int'(col_valid), 0);
    chk(burst_last == 1'b0, "R1 last after reset", int'(burst_last), 0);

    // R4 R5 R11 sweep: all fixed lengths, both orders, every start column
    for (int code = 0; code < 4; code++)
      for (int o = 0; o < 2; o++)
        for (int s = 0; s < 512; s++)
          run_fixed(code, o[0], s);

    // R11 reserved codes behave as a single beat
    for (int code = 4; code < 7; code++) begin
      run_fixed(code, 1'b0, 77 + code);
      run_fixed(code, 1'b1, 300 + code);
    end

    // R7 full page from near the top, interleave requested but ignored
    @(negedge clk);
    cmd_load = 1'b1; load_col = 9'd500; burst_len_sel = 3'd7; order_ilv = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0; burst_len_sel = 3'd0;
    for (int i = 0; i < 520; i++) begin
      chk(col_valid == 1'b1, "R7 page valid", int'(col_valid), 1);
      chk(int'(col_addr) == (500 + i) % 512, "R7 page column wrap", int'(col_addr), (500 + i) % 512);
      chk(burst_last == 1'b0, "R7 page never last", int'(burst_last), 0);
      if (i == 519) burst_stop = 1'b1;
      @(negedge clk);
    end
    burst_stop = 1'b0;
    chk(col_valid == 1'b0, "R8 stop ends page burst", int'(col_valid), 0);

    // R8 stop in the middle of an 8-beat burst
    @(negedge clk);
    cmd_load = 1'b1; load_col = 9'd10; burst_len_sel = 3'd3; order_ilv = 1'b0;
    @(negedge clk);
    cmd_load = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(int'(col_addr) == 12, "R8 column before stop", int'(col_addr), 12);
    burst_stop = 1'b1;
    @(negedge clk);
    burst_stop = 1'b0;
    chk(col_valid == 1'b0, "R8 valid after stop", int'(col_valid), 0);
    chk(burst_last == 1'b0, "R8 no last after stop", int'(burst_last), 0);

    // R9 reload mid-burst together with stop: load wins, new mode applies
    @(negedge clk);
    cmd_load = 1'b1; load_col = 9'd100; burst_len_sel = 3'd3; order_ilv = 1'b0;
    @(negedge clk);
    cmd_load = 1'b0;
    @(negedge clk);
    chk(int'(col_addr) == 101, "R9 first burst beat 1", int'(col_addr), 101);
    cmd_load = 1'b1; burst_stop = 1'b1; load_col = 9'd37; burst_len_sel = 3'd2; order_ilv = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0; burst_stop = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(col_valid == 1'b1, "R9 restarted valid", int'(col_valid), 1);
      chk(int'(col_addr) == exp_col(37, 4, 1'b1, i), "R9 restarted column",
          int'(col_addr), exp_col(37, 4, 1'b1, i));
      chk(burst_last == (i == 3), "R9 restarted last", int'(burst_last), int'(i == 3));
      @(negedge clk);
    end
    chk(col_valid == 1'b0, "R9 restarted burst ends", int'(col_valid), 0);

    summary();
  end
endmodule